// File: doc/BRIEF.md
# MDIO Management Frame Master

This block sends management frames to an Ethernet PHY over a two-wire management interface. It drives a management clock (MDC) and one data line (MDIO) that both sides share. A single-cycle request carries the operation (read or write), a 5-bit PHY address and a 5-bit register address. A write request also carries 16 bits of data. The block then shifts the whole frame out one bit per management clock period.

For a write, every bit of the frame is driven. For a read, the block drives the header and then releases the data line. It clocks in the turnaround bit and the 16 data bits. The turnaround bit is thrown away and the 16-bit result is presented. A direction output goes to the pad, so the tristate buffer drives only while the block owns the line.

The preamble is short: a parameter sets its length, with a default of six ones. The MDC half-period is a parameter counted in system clock cycles. Its default is 250 cycles, which is 1 µs at a 250 MHz system clock.

Top module: `mdio_master`

## Requirements
- R1: After synchronous reset, mdc is 0, mdio_oe is 0, busy is 0 and done is 0.
- R2: Every frame begins with PRE_LEN one-bits (default 6) and then the start pattern 0,1.
- R3: After the start pattern comes a 2-bit opcode: 1,0 for a read (req_write=0) and 0,1 for a write (req_write=1).
- R4: After the opcode come the PHY address and then the register address, 5 bits each, most significant bit first.
- R5: A write frame continues with the turnaround bits 1,0 and then the 16 data bits, most significant bit first. All PRE_LEN+32 bits are driven, with mdio_oe at 1 on every rising MDC edge of the frame.
- R6: A read frame drives PRE_LEN+14 bits and then holds mdio_oe at 0 for 17 more MDC periods. mdio_in is sampled in each of those periods. The first sampled bit is discarded and the next 16 bits form rd_data, first-sampled bit as bit 15.
- R7: During a frame, each MDC high phase and each MDC low phase lasts HALF_CYCLES system clocks. mdio_out and mdio_oe change only while mdc is low. mdio_in is sampled in the last system cycle of a high phase.
- R8: When a frame ends, mdc is left at 0 and mdio_oe at 0.
- R9: busy rises in the cycle after a request is accepted and falls on the last falling MDC edge of the frame. A request made while busy is 1 is ignored.
- R10: done is a one-cycle pulse, once per frame, in the cycle busy falls. For a read, rd_data holds the result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted while idle |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Data for a write frame |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Result of the last read frame |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data value for the pad when driven |
| mdio_oe | output | 1 | 1 while the block drives the data pad |
| mdio_in | input | 1 | Data value seen at the pad |

## Verification
The hardest case to reach from the ports is the read turnaround. The sampled bit that gets discarded must really be the first one after the line is released, and not one of the data bits. To test this, the bench models a PHY that counts rising MDC edges from the start of the frame. It places a chosen 17-bit response on mdio_in, one bit per period, starting exactly when the line is released. It then checks that a turnaround value of 1 never leaks into rd_data. A second hard case is a request that arrives in the middle of a frame. The bench pulses a read request with different addresses while a write is in progress. It then checks that the captured bit stream and the number of MDC edges match the write frame alone.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] TA_WRITE  = 2'b10;
  // header bits after preamble: start, opcode, two addresses
  localparam int HDR_TAIL = 2 + 2 + 2 * ADDR_W;
  // bits clocked after the header: turnaround plus data
  localparam int BODY_LEN = 2 + DATA_W;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int HALF_CYCLES = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int TW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == LAST);

  // R7: the counter never leaves its range
  a_r7_timer_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= LAST));
endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 6,
  parameter int FRAME_W = PRE_LEN + HDR_TAIL + BODY_LEN,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              is_write,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   n_drive,
  output logic [CNT_W-1:0]   n_total
);
  localparam int HDR_W   = PRE_LEN + HDR_TAIL;
  localparam int RD_TOT  = HDR_W + 1 + DATA_W;

  logic [HDR_W-1:0]    hdr;
  logic [BODY_LEN-1:0] body;

  always_comb begin
    hdr  = {{PRE_LEN{1'b1}}, START_PAT, (is_write ? OPC_WRITE : OPC_READ), phy, regad};
    body = is_write ? {TA_WRITE, wdata} : '0;
    frame = {hdr, body};
    n_drive = is_write ? CNT_W'(FRAME_W) : CNT_W'(HDR_W);
    n_total = is_write ? CNT_W'(FRAME_W) : CNT_W'(RD_TOT);
  end
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              din,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      data <= '0;
    end else if (en) begin
      data <= {data[DATA_W-2:0], din};
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYCLES = 250,
  parameter int PRE_LEN     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  localparam int FRAME_W = PRE_LEN + HDR_TAIL + BODY_LEN;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               busy_q, hi_q, mdc_q, mdo_q, oe_q, done_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   bit_q, ndrv_q, ntot_q;
  logic [FRAME_W-1:0] frame_w;
  logic [CNT_W-1:0]   ndrv_w, ntot_w;
  logic               tick, accept, rx_en, last_bit;
  logic [CNT_W-1:0]   bit_nx;

  mdio_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .run(busy_q), .tick(tick)
  );

  mdio_frame_build #(.PRE_LEN(PRE_LEN), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_build (
    .is_write(req_write), .phy(req_phy), .regad(req_reg), .wdata(req_wdata),
    .frame(frame_w), .n_drive(ndrv_w), .n_total(ntot_w)
  );

  assign accept   = req_valid && !busy_q;
  assign bit_nx   = bit_q + 1'b1;
  assign last_bit = (bit_nx == ntot_q);
  assign rx_en    = busy_q && tick && hi_q && (bit_q >= ndrv_q);

  mdio_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .clr(accept), .en(rx_en), .din(mdio_in), .data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      mdc_q  <= 1'b0;
      mdo_q  <= 1'b1;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
      ndrv_q <= '0;
      ntot_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        hi_q   <= 1'b0;
        mdc_q  <= 1'b0;
        sh_q   <= frame_w;
        mdo_q  <= frame_w[FRAME_W-1];
        oe_q   <= 1'b1;
        bit_q  <= '0;
        ndrv_q <= ndrv_w;
        ntot_q <= ntot_w;
      end else if (busy_q && tick) begin
        if (!hi_q) begin
          mdc_q <= 1'b1;
          hi_q  <= 1'b1;
        end else begin
          mdc_q <= 1'b0;
          hi_q  <= 1'b0;
          if (last_bit) begin
            busy_q <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_nx;
            sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
            mdo_q <= sh_q[FRAME_W-2];
            oe_q  <= (bit_nx < ndrv_q);
          end
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign mdc      = mdc_q;
  assign mdio_out = mdo_q;
  assign mdio_oe  = oe_q;

  // R7: pad value and direction hold while the clock is high
  a_r7_stable_high: assert property (@(posedge clk) disable iff (rst)
    (mdc_q && $past(mdc_q)) |-> ($stable(mdo_q) && $stable(oe_q)));
  // R8: idle leaves the clock low and the pad released
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!mdc_q && !oe_q));
  // R10: done lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R9/R10: busy ends exactly with the done pulse
  a_r9_busy_end_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);
  // R9: a request during a frame does not restart it
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && req_valid) |=> (bit_q >= $past(bit_q) || !busy_q));
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int HALF = 3;
  localparam int PRE  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, mdc, mdio_out, mdio_oe, mdio_in;
  logic [15:0] rd_data;

  int checks = 0, errors = 0, cycles = 0;
  int rise_cnt = 0, base_rise = 0, done_cnt = 0;
  int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
  logic prev_mdc = 1'b0;
  logic [63:0] cap = '0, oecap = '0;
  logic [16:0] resp = '1;

  always #2 clk = ~clk;

  mdio_master #(.HALF_CYCLES(HALF), .PRE_LEN(PRE)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  // PHY model: response bit k appears after rising edge PRE+14+1+k of the frame
  always_comb begin
    int rel;
    rel = rise_cnt - base_rise;
    if (rel >= PRE + 15 && rel <= PRE + 31) mdio_in = resp[16 - (rel - PRE - 15)];
    else mdio_in = 1'b1;
  end

  always @(negedge clk) begin
    cycles++;
    if (mdc && !prev_mdc) begin
      cap = {cap[62:0], mdio_out};
      oecap = {oecap[62:0], mdio_oe};
      rise_cnt++;
      last_lo = lo_run;
      hi_run = 1;
    end else if (mdc) hi_run++;
    if (!mdc && prev_mdc) begin
      last_hi = hi_run;
      lo_run = 1;
    end else if (!mdc) lo_run++;
    if (done) done_cnt++;
    prev_mdc = mdc;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd);
    @(negedge clk);
    base_rise = rise_cnt;
    done_cnt = 0;
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 busy after accept", 64'(busy), 64'd1);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    check("R1 mdc", 64'(mdc), 0);
    check("R1 oe", 64'(mdio_oe), 0);
    check("R1 busy", 64'(busy), 0);
    check("R1 done", 64'(done), 0);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    logic [37:0] exp;
    exp = {6'h3f, 2'b01, 2'b01, phy, rg, 2'b10, wd};
    issue(1'b1, phy, rg, wd);
    wait_done();
    check("R10 done seen", 64'(done), 1);
    check("R9 busy low at done", 64'(busy), 0);
    check("R8 mdc low at end", 64'(mdc), 0);
    check("R8 oe off at end", 64'(mdio_oe), 0);
    check("R2 preamble and start", 64'(cap[37:30]), 64'({6'h3f, 2'b01}));
    check("R3 write opcode", 64'(cap[29:28]), 64'(2'b01));
    check("R4 addresses", 64'(cap[27:18]), 64'({phy, rg}));
    check("R5 write frame", 64'(cap[37:0]), 64'(exp));
    check("R5 driven every bit", 64'(oecap[37:0]), 64'({38{1'b1}}));
    check("R5 clock count", 64'(rise_cnt - base_rise), 38);
    check("R7 high width", 64'(last_hi), HALF);
    check("R7 low width", 64'(last_lo), HALF);
    repeat (3) @(negedge clk);
    check("R10 single done", 64'(done_cnt), 1);
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic ta,
                        input logic [15:0] dat);
    resp = {ta, dat};
    issue(1'b0, phy, rg, 16'h0);
    wait_done();
    check("R6 read data", 64'(rd_data), 64'(dat));
    check("R10 busy low at done", 64'(busy), 0);
    check("R3 read opcode", 64'(cap[28:27]), 64'(2'b10));
    check("R4 read addresses", 64'(cap[26:17]), 64'({phy, rg}));
    check("R2 read preamble", 64'(cap[36:29]), 64'({6'h3f, 2'b01}));
    check("R6 release pattern", 64'(oecap[36:0]), 64'({{20{1'b1}}, 17'h0}));
    check("R6 clock count", 64'(rise_cnt - base_rise), 37);
    check("R8 oe off", 64'(mdio_oe), 0);
    repeat (3) @(negedge clk);
    check("R10 single done", 64'(done_cnt), 1);
    check("R6 data held", 64'(rd_data), 64'(dat));
  endtask

  task automatic t_ignore_busy();
    logic [37:0] exp;
    int r;
    exp = {6'h3f, 2'b01, 2'b01, 5'h03, 5'h11, 2'b10, 16'h1234};
    issue(1'b1, 5'h03, 5'h11, 16'h1234);
    repeat (40) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_phy = 5'h1c; req_reg = 5'h07;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    check("R9 frame unchanged", 64'(cap[37:0]), 64'(exp));
    check("R9 clock count", 64'(rise_cnt - base_rise), 38);
    r = rise_cnt;
    repeat (30) @(negedge clk);
    check("R9 no late frame", 64'(rise_cnt), 64'(r));
    check("R9 idle after", 64'(busy), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write(5'h15, 5'h0a, 16'hbeef);
    t_write(5'h00, 5'h1f, 16'h0001);
    t_read(5'h10, 5'h01, 1'b0, 16'ha5c3);
    t_read(5'h1f, 5'h00, 1'b1, 16'h0001);
    t_ignore_busy();
    t_read(5'h01, 5'h1e, 1'b1, 16'hffff);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule